// File: doc/BRIEF.md
# RV32I Immediate Generator

This block is a purely combinational decoder that turns one 32-bit RV32I instruction word into the 32-bit immediate operand carried by that instruction. It looks only at the 7-bit opcode to choose among five encoding layouts:
- register-immediate, for loads, arithmetic/logic immediates (shifts included) and indirect jumps;
- store;
- conditional branch;
- upper-immediate, for load-upper and add-upper-to-PC;
- direct jump.

It then gathers the immediate bits that the layout spreads across the word and places them in order. The signed layouts are widened by replicating the instruction's top bit. The branch and jump offsets get an implied zero least significant bit, and the upper-immediate layout gets twelve zero low bits.

A small format code is also brought out so that a debug view or a neighbouring decode stage can see which layout was chosen. An opcode outside the supported set yields a zero immediate and the "none" code. The unit sits in the fetch/decode stage between the instruction register and the operand multiplexers. It holds no state and adds no cycle of latency.

Top module: `imm_gen`

## Requirements
- R1: `fmt_o` encodes the chosen layout as 0 = none, 1 = register-immediate, 2 = store, 3 = branch, 4 = upper, 5 = jump. The mapping from opcode (`instr_i[6:0]`) is: 0000011, 0010011 and 1100111 give 1; 0100011 gives 2; 1100011 gives 3; 0110111 and 0010111 give 4; 1101111 gives 5.
- R2: For the register-immediate layout, `imm_o` equals `instr_i[31:20]` read as a signed 12-bit number.
- R3: For opcode 0010011 with `instr_i[14:12]` equal to 001 or 101 (shift by immediate), `imm_o[4:0]` equals the shift amount `instr_i[24:20]`.
- R4: For the store layout, `imm_o` equals the signed 12-bit value `{instr_i[31:25], instr_i[11:7]}`.
- R5: For the branch layout, `imm_o` equals the signed 13-bit value `{instr_i[31], instr_i[7], instr_i[30:25], instr_i[11:8], 0}`, so bit 0 is always 0.
- R6: For the jump layout, `imm_o` equals the signed 21-bit value `{instr_i[31], instr_i[19:12], instr_i[20], instr_i[30:21], 0}`, so bit 0 is always 0.
- R7: For the upper layout, `imm_o[31:12]` equals `instr_i[31:12]` and `imm_o[11:0]` is zero.
- R8: For any other opcode, `imm_o` is zero and `fmt_o` is 0.
- R9: For every signed layout (codes 1, 2, 3, 5), `imm_o[31]` equals `instr_i[31]`, whatever the other instruction bits are.
- R10: The outputs depend only on the current `instr_i`. A new word presented in a cycle is fully reflected in that same cycle, with no effect left over from earlier words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| imm_o | output | 32 | Reassembled, widened immediate |
| fmt_o | output | 3 | Chosen layout code (0 none, 1 reg-imm, 2 store, 3 branch, 4 upper, 5 jump) |

## Verification
Sign replication and the implied zero low bit land on the same output word whenever a branch or jump word has its top bit set. Such a word must produce a negative even offset. Bit patterns such as all-ones branch and jump words provoke that case deliberately, and the random stream hits it often. Each one is judged against an offset that the bench forms by adding signed field weights, not by splicing bits. A second overlap is a shift-immediate whose upper bits are set: the shift amount must still sit untouched in the low five bits while bit 31 follows the sign rule.

// File: rtl/imm_gen_pkg.sv
package imm_gen_pkg;

  localparam int ILEN    = 32;
  localparam int OPC_W   = 7;
  localparam int FMT_W   = 3;
  localparam int NUM_FMT = 6;

  typedef enum logic [FMT_W-1:0] {
    FMT_NONE = 3'd0,
    FMT_REGI = 3'd1,
    FMT_STOR = 3'd2,
    FMT_BRCH = 3'd3,
    FMT_UPPR = 3'd4,
    FMT_JUMP = 3'd5
  } fmt_e;

  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_ARITHI = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_JREG   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_LDUP   = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_ADDUP  = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_JDIR   = 7'b1101111;

  // Opcode to layout selection.
  function automatic fmt_e opcode_to_fmt(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_LOAD, OPC_ARITHI, OPC_JREG: opcode_to_fmt = FMT_REGI;
      OPC_STORE:                      opcode_to_fmt = FMT_STOR;
      OPC_BRANCH:                     opcode_to_fmt = FMT_BRCH;
      OPC_LDUP, OPC_ADDUP:            opcode_to_fmt = FMT_UPPR;
      OPC_JDIR:                       opcode_to_fmt = FMT_JUMP;
      default:                        opcode_to_fmt = FMT_NONE;
    endcase
  endfunction

  // Replicate bit 'msb' of v into every bit above it.
  function automatic logic [ILEN-1:0] widen_signed(input logic [ILEN-1:0] v,
                                                   input int unsigned msb);
    logic [ILEN-1:0] mask;
    mask = ~((ILEN'(1) << (msb + 1)) - ILEN'(1));
    widen_signed = v[msb] ? (v | mask) : (v & ~mask);
  endfunction

  // Gather the scattered fields of one layout.
  function automatic logic [ILEN-1:0] build_imm(input fmt_e f,
                                                input logic [ILEN-1:0] w);
    case (f)
      FMT_REGI: build_imm = widen_signed({20'b0, w[31:20]}, 11);
      FMT_STOR: build_imm = widen_signed({20'b0, w[31:25], w[11:7]}, 11);
      FMT_BRCH: build_imm = widen_signed({19'b0, w[31], w[7], w[30:25],
                                          w[11:8], 1'b0}, 12);
      FMT_UPPR: build_imm = {w[31:12], 12'b0};
      FMT_JUMP: build_imm = widen_signed({11'b0, w[31], w[19:12], w[20],
                                          w[30:21], 1'b0}, 20);
      default:  build_imm = '0;
    endcase
  endfunction

endpackage

// File: rtl/imm_fmt_decode.sv
module imm_fmt_decode
  import imm_gen_pkg::*;
#(
  parameter int W = ILEN
) (
  input  logic [W-1:0] instr_i,
  output fmt_e         fmt_o
);

  always_comb fmt_o = opcode_to_fmt(instr_i[OPC_W-1:0]);

endmodule

// File: rtl/imm_field_build.sv
module imm_field_build
  import imm_gen_pkg::*;
#(
  parameter int W = ILEN,
  parameter int N = NUM_FMT
) (
  input  logic [W-1:0]        instr_i,
  output logic [N-1:0][W-1:0] cand_o
);

  // One candidate per layout code; code 0 yields zero.
  for (genvar g = 0; g < N; g++) begin : g_cand
    assign cand_o[g] = build_imm(fmt_e'(FMT_W'(g)), instr_i);
  end

endmodule

// File: rtl/imm_select.sv
module imm_select
  import imm_gen_pkg::*;
#(
  parameter int W = ILEN,
  parameter int N = NUM_FMT
) (
  input  logic [N-1:0][W-1:0] cand_i,
  input  fmt_e                fmt_i,
  output logic [W-1:0]        imm_o
);

  always_comb begin
    imm_o = '0;
    for (int k = 0; k < N; k++) begin
      if (fmt_i == fmt_e'(FMT_W'(k))) imm_o = cand_i[k];
    end
  end

endmodule

// File: rtl/imm_gen.sv
module imm_gen
  import imm_gen_pkg::*;
(
  input  logic [ILEN-1:0]  instr_i,
  output logic [ILEN-1:0]  imm_o,
  output logic [FMT_W-1:0] fmt_o
);

  fmt_e                      fmt_sel;
  logic [NUM_FMT-1:0][ILEN-1:0] cand;

  // Named events for the checker.
  logic fmt_signed;
  logic lsb_forced;

  imm_fmt_decode #(.W(ILEN)) u_dec (
    .instr_i (instr_i),
    .fmt_o   (fmt_sel)
  );

  imm_field_build #(.W(ILEN), .N(NUM_FMT)) u_build (
    .instr_i (instr_i),
    .cand_o  (cand)
  );

  imm_select #(.W(ILEN), .N(NUM_FMT)) u_sel (
    .cand_i (cand),
    .fmt_i  (fmt_sel),
    .imm_o  (imm_o)
  );

  assign fmt_o      = fmt_sel;
  assign fmt_signed = (fmt_sel == FMT_REGI) || (fmt_sel == FMT_STOR) ||
                      (fmt_sel == FMT_BRCH) || (fmt_sel == FMT_JUMP);
  assign lsb_forced = (fmt_sel == FMT_BRCH) || (fmt_sel == FMT_JUMP);

endmodule

// File: rtl/imm_gen_chk.sv
module imm_gen_chk
  import imm_gen_pkg::*;
(
  input logic [ILEN-1:0]  instr_i,
  input logic [ILEN-1:0]  imm_o,
  input logic [FMT_W-1:0] fmt_o,
  input logic             fmt_signed,
  input logic             lsb_forced
);

  always_comb begin
    if (!$isunknown(instr_i)) begin
      p_fmt_legal_r1: assert (fmt_o <= 3'd5);
      p_shamt_kept_r3: assert (!(instr_i[6:0] == 7'b0010011 &&
                                 instr_i[13:12] == 2'b01) ||
                               imm_o[4:0] == instr_i[24:20]);
      p_brjmp_even_r5: assert (!lsb_forced || !imm_o[0]);
      p_upper_low_r7: assert (fmt_o != 3'd4 ||
                              (imm_o[11:0] == 12'h000 &&
                               imm_o[31:12] == instr_i[31:12]));
      p_none_zero_r8: assert (fmt_o != 3'd0 || imm_o == '0);
      p_sign_top_r9: assert (!fmt_signed || imm_o[31] == instr_i[31]);
    end
  end

endmodule

bind imm_gen imm_gen_chk u_chk (
  .instr_i    (instr_i),
  .imm_o      (imm_o),
  .fmt_o      (fmt_o),
  .fmt_signed (fmt_signed),
  .lsb_forced (lsb_forced)
);

// File: tb/imm_gen_tb.sv
module imm_gen_tb;

  logic        clk;
  logic        rst;
  logic [31:0] instr;
  logic [31:0] imm;
  logic [2:0]  fmt;
  int          checks;
  int          fails;
  bit          done;

  imm_gen u_dut (
    .instr_i (instr),
    .imm_o   (imm),
    .fmt_o   (fmt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference: layout code by opcode table (R1).
  function automatic int ref_fmt(input logic [31:0] w);
    case (w[6:0])
      7'h03, 7'h13, 7'h67: return 1;
      7'h23:               return 2;
      7'h63:               return 3;
      7'h37, 7'h17:        return 4;
      7'h6F:               return 5;
      default:             return 0;
    endcase
  endfunction

  // Reference: immediate by adding signed field weights.
  function automatic logic [31:0] ref_imm(input logic [31:0] w);
    longint v;
    case (ref_fmt(w))
      1: v = longint'(w[30:20]) - (w[31] ? 2048 : 0);
      2: v = longint'(w[30:25]) * 32 + longint'(w[11:7]) - (w[31] ? 2048 : 0);
      3: v = longint'(w[7]) * 2048 + longint'(w[30:25]) * 32 +
             longint'(w[11:8]) * 2 - (w[31] ? 4096 : 0);
      4: v = longint'(w[31:12]) * 4096;
      5: v = longint'(w[19:12]) * 4096 + longint'(w[20]) * 2048 +
             longint'(w[30:21]) * 2 - (w[31] ? 1048576 : 0);
      default: v = 0;
    endcase
    return v[31:0];
  endfunction

  function automatic string req_of(input int f);
    case (f)
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R7";
      5: return "R6";
      default: return "R8";
    endcase
  endfunction

  // Drive at a rising edge, judge at the following falling edge (R10).
  task automatic apply(input logic [31:0] w);
    logic [31:0] exp_imm;
    int          exp_fmt;
    @(posedge clk);
    instr = w;
    @(negedge clk);
    exp_imm = ref_imm(w);
    exp_fmt = ref_fmt(w);
    checks++;
    if (int'(fmt) != exp_fmt) begin
      fails++;
      $display("FAIL R1 word %h fmt actual %0d expected %0d", w, fmt, exp_fmt);
    end
    checks++;
    if (imm !== exp_imm) begin
      fails++;
      $display("FAIL %s/R10 word %h imm actual %h expected %h",
               req_of(exp_fmt), w, imm, exp_imm);
    end
    if (w[6:0] == 7'h13 && w[13:12] == 2'b01) begin
      checks++;
      if (imm[4:0] != w[24:20]) begin
        fails++;
        $display("FAIL R3 word %h shamt actual %0d expected %0d",
                 w, imm[4:0], w[24:20]);
      end
    end
    if (exp_fmt inside {1, 2, 3, 5}) begin
      checks++;
      if (imm[31] != w[31]) begin
        fails++;
        $display("FAIL R9 word %h top bit actual %b expected %b",
                 w, imm[31], w[31]);
      end
    end
  endtask

  localparam logic [6:0] OPS [9] = '{7'h03, 7'h13, 7'h67, 7'h23, 7'h63,
                                     7'h37, 7'h17, 7'h6F, 7'h33};

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    rst    = 1'b1;
    instr  = 32'h0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // Reset state: zero word is an unknown opcode (R8).
    checks++;
    if (imm !== 32'h0 || fmt !== 3'd0) begin
      fails++;
      $display("FAIL R8 reset imm actual %h expected 00000000 fmt %0d", imm, fmt);
    end
    rst = 1'b0;
    // Directed corners.
    apply(32'hFFF00093);  // R2 all-ones reg-imm
    apply(32'h7FF00013);  // R2 largest positive
    apply(32'h4030D093);  // R3 arithmetic right shift by 3
    apply(32'hFFF09013);  // R3 left-shift word with top bits set
    apply(32'hFE20AE23);  // R4 negative store offset
    apply(32'h7E000FA3);  // R4 positive store offset
    apply(32'hFFFFFFE3);  // R5 all-ones branch: -2
    apply(32'h80000063);  // R5 most negative branch
    apply(32'h7E000FE3);  // R5 largest positive branch
    apply(32'hFFFFFFEF);  // R6 all-ones jump: -2
    apply(32'h8000006F);  // R6 most negative jump
    apply(32'hFFFFF0B7);  // R7 upper, all ones
    apply(32'h12345017);  // R7 add-upper
    apply(32'hFFFFFFB3);  // R8 register-register opcode
    apply(32'hFFFFFFFF);  // R8 reserved opcode
    apply(32'hFFF00067);  // R2 indirect jump
    // Random stream, back-to-back words (R10).
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (i % 10 == 9) apply(r);
      else apply({r[31:7], OPS[$urandom_range(8, 0)]});
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule